// File: doc/BRIEF.md
# Interrupt Pending and Enable Controller

This block keeps the state of a bank of interrupt lines, 32 by default. Every line has three bits: enable, pending and active. Software reaches them through a small word-addressed register bus. Set and clear registers act only on the bits written as one, so several lines can be changed in one write without a read-modify-write.

Interrupt inputs are asynchronous and pass through a synchronizer. Each line is built either as a level source or as a pulse (edge) source. A one-clock acknowledge strobe moves the lowest-numbered eligible line from pending to active. A return strobe names a line index and takes that line out of the active state. A disabled line can still become pending. An active line keeps running when it is disabled.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After synchronous reset, all enable, pending and active bits are zero, `sel_valid` is low and every `line_status` field is 00.
- R2: A write to word address 0 sets, and a write to word address 1 clears, the enable bit of every line whose data bit is one. Zero bits have no effect. A read of either address returns the enable bits.
- R3: A write to word address 2 sets, and a write to word address 3 clears, the pending bit of every line whose data bit is one. Zero bits have no effect. A read of either address returns the pending bits.
- R4: On a pulse line, a rising edge of the synchronized input sets pending on the third clock edge after the input rises. A one-clock pulse is enough. This also works while the line is active.
- R5: On a level line, pending is held set while the synchronized input is high and the line is not active. If the input is still high when the line returns, pending is set again.
- R6: A disabled line can become pending but is never selected and never becomes active.
- R7: An active line stays active when its enable is cleared. Only a return naming its own index, or reset, clears it.
- R8: Writing one to a line's clear-pending bit leaves its active bit unchanged.
- R9: `sel_valid`/`sel_line` present the lowest-index line that is pending, enabled and not active. An `ack` clears that line's pending bit and sets its active bit on the same edge. An `ack` while `sel_valid` is low has no effect.
- R10: `line_status[2i+1:2i]` for line i is {active, pending}: 00 inactive, 01 pending, 10 active, 11 active and pending.
- R11: Word address 4 reads the active bits and word address 5 reads the number of lines. Writes to these two addresses are ignored. Bits for lines that do not exist read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_LINES | Asynchronous interrupt inputs |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational, zero when no read) |
| ack | input | 1 | Acknowledge the selected line |
| sel_valid | output | 1 | A line is eligible for acknowledge |
| sel_line | output | IW | Index of the eligible line |
| ret_valid | input | 1 | Return from the line in `ret_line` |
| ret_line | input | IW | Index of the returning line |
| line_status | output | 2*NUM_LINES | Per-line {active, pending} |

## Verification
The bench builds two instances:
- One with 32 lines, lines 0 to 15 as level sources and 16 to 31 as pulse sources. This covers the exact synchronizer latency, re-pending while active, and re-pending of a level line on return.
- One with 5 lines. Its type register reads 5, and write-one-to-all enables read back as 0x1F, so the masking of lines that do not exist is visible at the bus.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int REG_AW = 3;

    typedef enum logic [1:0] {
        LS_IDLE = 2'b00,
        LS_PEND = 2'b01,
        LS_ACT  = 2'b10,
        LS_BOTH = 2'b11
    } line_state_t;

    typedef enum logic [REG_AW-1:0] {
        RA_EN_SET = 3'd0,
        RA_EN_CLR = 3'd1,
        RA_PD_SET = 3'd2,
        RA_PD_CLR = 3'd3,
        RA_ACTIVE = 3'd4,
        RA_TYPE   = 3'd5
    } reg_addr_t;

    typedef struct packed {
        logic en_set;
        logic en_clr;
        logic pd_set;
        logic pd_clr;
    } wr_decode_t;

    function automatic line_state_t encode_state(input logic act, input logic pend);
        return line_state_t'({act, pend});
    endfunction

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int NUM_LINES = 32,
    parameter int STAGES    = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] async_in,
    output logic [NUM_LINES-1:0] lvl,
    output logic [NUM_LINES-1:0] rise
);

    logic [STAGES-1:0][NUM_LINES-1:0] chain;
    logic [NUM_LINES-1:0]             prev;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= '0;
                else     chain[0] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= chain[STAGES-1];
    end

    assign lvl  = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~prev;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
        assert_rise_single_R4: assert property (@(posedge clk) disable iff (rst)
            rise[i] |=> !rise[i]);
    end

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int NUM_LINES = 32,
    localparam int IW = irq_pkg::idx_width(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] cand,
    output logic                 valid,
    output logic [IW-1:0]        idx,
    output logic [NUM_LINES-1:0] grant
);

    always_comb begin
        valid = 1'b0;
        idx   = '0;
        grant = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (cand[i]) begin
                valid = 1'b1;
                idx   = IW'(i);
                grant = '0;
                grant[i] = 1'b1;
            end
        end
    end

    assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    assert_grant_is_cand_R9: assert property (@(posedge clk) disable iff (rst)
        valid |-> cand[idx]);

endmodule

// File: rtl/irq_regbus.sv
module irq_regbus
    import irq_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [REG_AW-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic [NUM_LINES-1:0] en_q,
    input  logic [NUM_LINES-1:0] pend_q,
    input  logic [NUM_LINES-1:0] act_q,
    output logic [NUM_LINES-1:0] en_set,
    output logic [NUM_LINES-1:0] en_clr,
    output logic [NUM_LINES-1:0] pd_set,
    output logic [NUM_LINES-1:0] pd_clr,
    output logic [DATA_W-1:0]    bus_rdata
);

    wr_decode_t           dec;
    logic [NUM_LINES-1:0] wbits;

    assign wbits = bus_wdata[NUM_LINES-1:0];

    always_comb begin
        dec = '0;
        if (bus_sel && bus_we) begin
            case (reg_addr_t'(bus_addr))
                RA_EN_SET: dec.en_set = 1'b1;
                RA_EN_CLR: dec.en_clr = 1'b1;
                RA_PD_SET: dec.pd_set = 1'b1;
                RA_PD_CLR: dec.pd_clr = 1'b1;
                default:   dec = '0;
            endcase
        end
    end

    assign en_set = dec.en_set ? wbits : '0;
    assign en_clr = dec.en_clr ? wbits : '0;
    assign pd_set = dec.pd_set ? wbits : '0;
    assign pd_clr = dec.pd_clr ? wbits : '0;

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            case (reg_addr_t'(bus_addr))
                RA_EN_SET, RA_EN_CLR: bus_rdata[NUM_LINES-1:0] = en_q;
                RA_PD_SET, RA_PD_CLR: bus_rdata[NUM_LINES-1:0] = pend_q;
                RA_ACTIVE:            bus_rdata[NUM_LINES-1:0] = act_q;
                RA_TYPE:              bus_rdata = DATA_W'(NUM_LINES);
                default:              bus_rdata = '0;
            endcase
        end
    end

    assert_strobes_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        $countones({|en_set, |en_clr, |pd_set, |pd_clr}) <= 1);

endmodule

// File: rtl/irq_line_bank.sv
module irq_line_bank #(
    parameter int          NUM_LINES  = 32,
    parameter logic [31:0] LEVEL_MASK = 32'h0000_FFFF,
    localparam int IW = irq_pkg::idx_width(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] en_set,
    input  logic [NUM_LINES-1:0] en_clr,
    input  logic [NUM_LINES-1:0] pd_set,
    input  logic [NUM_LINES-1:0] pd_clr,
    input  logic [NUM_LINES-1:0] lvl,
    input  logic [NUM_LINES-1:0] rise,
    input  logic [NUM_LINES-1:0] grant,
    input  logic                 ack,
    input  logic                 ret_valid,
    input  logic [IW-1:0]        ret_line,
    output logic [NUM_LINES-1:0] en_q,
    output logic [NUM_LINES-1:0] pend_q,
    output logic [NUM_LINES-1:0] act_q
);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic take;
        logic ret_hit;
        logic hw_set;

        assign take    = ack && grant[i];
        assign ret_hit = ret_valid && (ret_line == IW'(i));

        if (LEVEL_MASK[i]) begin : g_level
            assign hw_set = lvl[i] && !act_q[i] && !take;
        end else begin : g_pulse
            assign hw_set = rise[i];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                en_q[i]   <= 1'b0;
                pend_q[i] <= 1'b0;
                act_q[i]  <= 1'b0;
            end else begin
                if (en_set[i])      en_q[i] <= 1'b1;
                else if (en_clr[i]) en_q[i] <= 1'b0;

                if (hw_set || pd_set[i])     pend_q[i] <= 1'b1;
                else if (pd_clr[i] || take)  pend_q[i] <= 1'b0;

                if (take)         act_q[i] <= 1'b1;
                else if (ret_hit) act_q[i] <= 1'b0;
            end
        end

        assert_act_needs_enabled_ack_R6: assert property (@(posedge clk) disable iff (rst)
            $rose(act_q[i]) |-> $past(take && en_q[i]));
        assert_disable_keeps_act_R7: assert property (@(posedge clk) disable iff (rst)
            (act_q[i] && en_clr[i] && !ret_hit) |=> act_q[i]);
        assert_clrpend_keeps_act_R8: assert property (@(posedge clk) disable iff (rst)
            (pd_clr[i] && !ret_hit && !take) |=> $stable(act_q[i]));
    end

endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
    import irq_pkg::*;
#(
    parameter int          NUM_LINES   = 32,
    parameter int          SYNC_STAGES = 2,
    parameter logic [31:0] LEVEL_MASK  = 32'h0000_FFFF,
    localparam int IW     = idx_width(NUM_LINES),
    localparam int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_LINES-1:0]   irq_in,
    input  logic                   bus_sel,
    input  logic                   bus_we,
    input  logic [REG_AW-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic                   ack,
    output logic                   sel_valid,
    output logic [IW-1:0]          sel_line,
    input  logic                   ret_valid,
    input  logic [IW-1:0]          ret_line,
    output logic [2*NUM_LINES-1:0] line_status
);

    logic [NUM_LINES-1:0] lvl, rise;
    logic [NUM_LINES-1:0] en_set, en_clr, pd_set, pd_clr;
    logic [NUM_LINES-1:0] en_q, pend_q, act_q;
    logic [NUM_LINES-1:0] cand, grant;

    irq_sync #(.NUM_LINES(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(irq_in), .lvl(lvl), .rise(rise)
    );

    irq_regbus #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_bus (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .en_q(en_q), .pend_q(pend_q), .act_q(act_q),
        .en_set(en_set), .en_clr(en_clr), .pd_set(pd_set), .pd_clr(pd_clr),
        .bus_rdata(bus_rdata)
    );

    assign cand = pend_q & en_q & ~act_q;

    irq_pick #(.NUM_LINES(NUM_LINES)) u_pick (
        .clk(clk), .rst(rst), .cand(cand), .valid(sel_valid), .idx(sel_line), .grant(grant)
    );

    irq_line_bank #(.NUM_LINES(NUM_LINES), .LEVEL_MASK(LEVEL_MASK)) u_bank (
        .clk(clk), .rst(rst),
        .en_set(en_set), .en_clr(en_clr), .pd_set(pd_set), .pd_clr(pd_clr),
        .lvl(lvl), .rise(rise), .grant(grant), .ack(ack),
        .ret_valid(ret_valid), .ret_line(ret_line),
        .en_q(en_q), .pend_q(pend_q), .act_q(act_q)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_status
        assign line_status[2*i +: 2] = encode_state(act_q[i], pend_q[i]);
    end

    assert_sel_eligible_R9: assert property (@(posedge clk) disable iff (rst)
        sel_valid |-> (en_q[sel_line] && pend_q[sel_line] && !act_q[sel_line]));
    assert_ack_moves_line_R9: assert property (@(posedge clk) disable iff (rst)
        (ack && sel_valid && !ret_valid) |=> act_q[$past(sel_line)]);

endmodule

// File: tb/sim_irq_pend_ctrl.sv
module sim_irq_pend_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_in = '0;
    logic        sel0 = 1'b0, sel1 = 1'b0, we = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata0, rdata1;
    logic        ack = 1'b0, ret_valid = 1'b0;
    logic [4:0]  ret_line = '0;
    logic        sel_valid;
    logic [4:0]  sel_line;
    logic [63:0] status;
    logic        sel_valid1;
    logic [2:0]  sel_line1;
    logic [9:0]  status1;

    int vecs = 0;
    int miss = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_pend_ctrl #(.NUM_LINES(32), .LEVEL_MASK(32'h0000_FFFF)) u0 (
        .clk(clk), .rst(rst), .irq_in(irq_in),
        .bus_sel(sel0), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata0),
        .ack(ack), .sel_valid(sel_valid), .sel_line(sel_line),
        .ret_valid(ret_valid), .ret_line(ret_line), .line_status(status)
    );

    irq_pend_ctrl #(.NUM_LINES(5), .LEVEL_MASK(32'h0000_0003)) u1 (
        .clk(clk), .rst(rst), .irq_in(5'b0),
        .bus_sel(sel1), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata1),
        .ack(1'b0), .sel_valid(sel_valid1), .sel_line(sel_line1),
        .ret_valid(1'b0), .ret_line(3'b0), .line_status(status1)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int which, input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        sel0 = (which == 0); sel1 = (which == 1); we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel0 = 1'b0; sel1 = 1'b0; we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input int which, input logic [2:0] a, output logic [31:0] v);
        sel0 = (which == 0); sel1 = (which == 1); we = 1'b0; addr = a;
        #1;
        v = (which == 0) ? rdata0 : rdata1;
        sel0 = 1'b0; sel1 = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic pulse_ret(input logic [4:0] line);
        @(negedge clk); ret_valid = 1'b1; ret_line = line;
        @(negedge clk); ret_valid = 1'b0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clean();
        wr(0, 3'd1, 32'hFFFF_FFFF);
        wr(0, 3'd3, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(0, 3'd0, v); chk("R1 enable after reset", v, 32'h0);
        rd(0, 3'd2, v); chk("R1 pending after reset", v, 32'h0);
        rd(0, 3'd4, v); chk("R1 active after reset", v, 32'h0);
        chk("R1 sel_valid after reset", {31'b0, sel_valid}, 32'h0);
        chk("R1 status after reset", status[31:0] | status[63:32], 32'h0);
        rd(0, 3'd5, v); chk("R11 type reg 32 lines", v, 32'd32);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr(0, 3'd0, 32'h0000_00F0);
        rd(0, 3'd0, v); chk("R2 set-enable read", v, 32'h0000_00F0);
        rd(0, 3'd1, v); chk("R2 clear-enable read", v, 32'h0000_00F0);
        wr(0, 3'd1, 32'h0000_0030);
        rd(0, 3'd0, v); chk("R2 clear two lines", v, 32'h0000_00C0);
        wr(0, 3'd0, 32'h0);
        wr(0, 3'd1, 32'h0);
        rd(0, 3'd1, v); chk("R2 zero writes ignored", v, 32'h0000_00C0);
        clean();
    endtask

    task automatic t_soft_pend();
        logic [31:0] v;
        wr(0, 3'd2, 32'h8000_0003);
        rd(0, 3'd2, v); chk("R3 set-pending read", v, 32'h8000_0003);
        chk("R10 pending-only status line 1", {30'b0, status[3:2]}, 32'h1);
        wr(0, 3'd3, 32'h0000_0001);
        rd(0, 3'd3, v); chk("R3 clear-pending read", v, 32'h8000_0002);
        wr(0, 3'd2, 32'h0);
        rd(0, 3'd2, v); chk("R3 zero write ignored", v, 32'h8000_0002);
        clean();
        rd(0, 3'd2, v); chk("R3 clear all", v, 32'h0);
    endtask

    task automatic t_pick();
        logic [31:0] v;
        wr(0, 3'd2, 32'h0000_0288);
        wr(0, 3'd0, 32'h0000_0080);
        chk("R6 disabled line 3 skipped", {sel_valid, 26'b0, sel_line}, {1'b1, 26'b0, 5'd7});
        wr(0, 3'd0, 32'h0000_0008);
        chk("R9 lowest index picked", {sel_valid, 26'b0, sel_line}, {1'b1, 26'b0, 5'd3});
        pulse_ack();
        rd(0, 3'd4, v); chk("R9 ack sets active", v, 32'h0000_0008);
        rd(0, 3'd2, v); chk("R9 ack clears pending", v, 32'h0000_0280);
        chk("R10 active-only status line 3", {30'b0, status[7:6]}, 32'h2);
        chk("R9 next line offered", {sel_valid, 26'b0, sel_line}, {1'b1, 26'b0, 5'd7});
        pulse_ret(5'd3);
        rd(0, 3'd4, v); chk("R9 return clears active", v, 32'h0);
        wr(0, 3'd3, 32'h0000_0080);
        chk("R6 only disabled pending left", {31'b0, sel_valid}, 32'h0);
        pulse_ack();
        rd(0, 3'd4, v); chk("R6 ack with nothing eligible", v, 32'h0);
        rd(0, 3'd2, v); chk("R6 disabled line stays pending", v, 32'h0000_0200);
        clean();
    endtask

    task automatic t_pulse();
        logic [31:0] v;
        wr(0, 3'd0, 32'h0010_0000);
        irq_in[20] = 1'b1;
        @(negedge clk); irq_in[20] = 1'b0;
        @(negedge clk);
        rd(0, 3'd2, v); chk("R4 not pending after two edges", v, 32'h0);
        @(negedge clk);
        rd(0, 3'd2, v); chk("R4 one-clock pulse pends on third edge", v, 32'h0010_0000);
        pulse_ack();
        rd(0, 3'd4, v); chk("R4 pulse line active", v, 32'h0010_0000);
        @(negedge clk); irq_in[20] = 1'b1;
        @(negedge clk); irq_in[20] = 1'b0;
        tick(3);
        chk("R4 R10 pend again while active", {30'b0, status[41:40]}, 32'h3);
        chk("R9 active line not offered", {31'b0, sel_valid}, 32'h0);
        pulse_ret(5'd20);
        chk("R9 offered after return", {sel_valid, 26'b0, sel_line}, {1'b1, 26'b0, 5'd20});
        wr(0, 3'd3, 32'h0010_0000);
        irq_in[20] = 1'b1;
        tick(4);
        wr(0, 3'd3, 32'h0010_0000);
        tick(3);
        rd(0, 3'd2, v); chk("R4 held high does not re-pend", v, 32'h0);
        irq_in[20] = 1'b0;
        tick(3);
        clean();
    endtask

    task automatic t_level();
        logic [31:0] v;
        wr(0, 3'd0, 32'h0000_0004);
        irq_in[2] = 1'b1;
        tick(4);
        rd(0, 3'd2, v); chk("R5 level pends", v, 32'h0000_0004);
        pulse_ack();
        tick(3);
        rd(0, 3'd2, v); chk("R5 no pend while active", v, 32'h0);
        pulse_ret(5'd2);
        tick(1);
        rd(0, 3'd2, v); chk("R5 re-pend after return", v, 32'h0000_0004);
        irq_in[2] = 1'b0;
        tick(3);
        pulse_ack();
        pulse_ret(5'd2);
        tick(2);
        rd(0, 3'd2, v); chk("R5 low input no re-pend", v, 32'h0);
        clean();
    endtask

    task automatic t_disable_active();
        logic [31:0] v;
        wr(0, 3'd0, 32'h0000_0020);
        wr(0, 3'd2, 32'h0000_0020);
        pulse_ack();
        wr(0, 3'd1, 32'h0000_0020);
        rd(0, 3'd4, v); chk("R7 active survives disable", v, 32'h0000_0020);
        wr(0, 3'd2, 32'h0000_0020);
        wr(0, 3'd3, 32'h0000_0020);
        rd(0, 3'd4, v); chk("R8 clear-pending keeps active", v, 32'h0000_0020);
        pulse_ret(5'd6);
        rd(0, 3'd4, v); chk("R7 other index return ignored", v, 32'h0000_0020);
        pulse_ret(5'd5);
        rd(0, 3'd4, v); chk("R7 own return clears", v, 32'h0);
        clean();
    endtask

    task automatic t_readonly();
        logic [31:0] v;
        wr(0, 3'd5, 32'hFFFF_FFFF);
        wr(0, 3'd4, 32'hFFFF_FFFF);
        rd(0, 3'd5, v); chk("R11 type reg write ignored", v, 32'd32);
        rd(0, 3'd4, v); chk("R11 active reg write ignored", v, 32'h0);
        rd(1, 3'd5, v); chk("R11 type reg 5 lines", v, 32'd5);
        wr(1, 3'd0, 32'hFFFF_FFFF);
        rd(1, 3'd0, v); chk("R11 missing lines read zero", v, 32'h0000_001F);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_enable();
        t_soft_pend();
        t_pick();
        t_pulse();
        t_level();
        t_disable_active();
        t_readonly();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vecs++;
            miss++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
            $finish;
        end
    end

endmodule